// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer behind a small register interface. It holds a 32-bit down-counter, a two-bit control register and a key register. The counter and control registers can be written only while the key register holds the unlock value. With the count-enable bit set, the counter falls by one per clock until it reaches zero. If the counter is zero while both count-enable and reset-enable are set, the block drives a system reset pulse of fixed length. At the end of that pulse every register returns to its power-up state.

Software arms the watchdog in four steps. It writes the key, loads a timeout, sets both control bits and, if it wants, writes a wrong key to lock the block again. To stay alive it reloads the counter while the block is unlocked. Loading zero and then setting both bits gives an immediate reset. Reads need no key. The counter read always returns the live value.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, address 0 (counter), address 1 (control) and address 2 (key) all read 0, and `wdt_rst_o` is low.
- R2: Writes to address 0 or address 1 are ignored unless the key register holds 0x482E. Writing any other value to address 2 locks the block again.
- R3: The key register stores `bus_wdata[15:0]`, and bits above 15 are ignored. While unlocked, a write to address 0 loads the counter and a write to address 1 sets reset-enable from bit 0 and count-enable from bit 2. Control reads return those two bits in the same positions.
- R4: While count-enable is set and the counter is nonzero, the counter falls by exactly one per clock. It holds its value while count-enable is clear.
- R5: No reset pulse starts unless count-enable and reset-enable are both set. With count-enable alone, the counter stays at zero once it gets there.
- R6: At the first clock edge at which the counter is zero and both enable bits are set, `wdt_rst_o` goes high. Loading 0 and then setting both bits gives a reset one clock after the control write.
- R7: `wdt_rst_o` stays high for exactly 16 clocks. When it falls, the key, control and counter registers are back to 0, so the block is locked and disabled.
- R8: Bus writes to any address, including the key, are ignored while `wdt_rst_o` is high.
- R9: A read of address 0 returns the live counter value whether the block is locked or not. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Register select: 0 counter, 1 control, 2 key |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational by default |
| wdt_rst_o | output | 1 | System reset pulse, active high |

## Verification
The checker assumes that `bus_we` and `bus_addr` are known on every clock after reset, and that a write lasts exactly one cycle. Its step and freeze properties depend on both. The bench changes every bus input only on the falling clock edge and drops `bus_we` after each single-cycle write. The one exception is a deliberate multi-cycle write held during the reset pulse, where every write must be ignored. Because the bench reads on the falling edge, each combinational read reflects the state after the preceding rising edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Register map; positions are decoded by software
   typedef enum logic [1:0] {
      WDT_A_COUNT = 2'd0,
      WDT_A_CTRL  = 2'd1,
      WDT_A_KEY   = 2'd2,
      WDT_A_NONE  = 2'd3
   } wdt_addr_e;

   localparam int CTRL_REN_BIT = 0;
   localparam int CTRL_CEN_BIT = 2;

   typedef struct packed {
      logic cen;
      logic ren;
   } wdt_ctrl_t;

endpackage

// File: rtl/wdt_key_gate.sv
module wdt_key_gate #(
   parameter int              KEY_W   = 16,
   parameter logic [KEY_W-1:0] KEY_VAL = 16'h482E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             key_we,
   input  logic [KEY_W-1:0] key_wdata,
   output logic [KEY_W-1:0] key_q,
   output logic             unlocked
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
      end else if (clear) begin
         key_q <= '0;
      end else if (key_we) begin
         key_q <= key_wdata;
      end
   end

   assign unlocked = (key_q == KEY_VAL);

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic [CNT_W-1:0] cnt_q,
   output logic             zero
);

   assign zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (run && !zero) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
   parameter int RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic active,
   output logic last
);

   localparam int PW = $clog2(RST_CYCLES + 1);

   logic [PW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (left_q != '0) begin
         left_q <= left_q - PW'(1);
      end else if (fire) begin
         left_q <= PW'(RST_CYCLES);
      end
   end

   assign active = (left_q != '0);
   assign last   = (left_q == PW'(1));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
   parameter int               DATA_W     = 32,
   parameter int               CNT_W      = 32,
   parameter int               KEY_W      = 16,
   parameter logic [KEY_W-1:0] KEY_VAL    = 16'h482E,
   parameter int               RST_CYCLES = 16,
   parameter bit               RDATA_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdt_rst_o
);
   import wdt_pkg::*;

   localparam int CTRL_MSB = (CTRL_CEN_BIT > CTRL_REN_BIT) ? CTRL_CEN_BIT : CTRL_REN_BIT;

   // Elaboration-time parameter checks
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("keyed_wdt: CNT_W must lie in 2..DATA_W");
   end
   if (KEY_W < 1 || KEY_W > DATA_W) begin : g_bad_key_w
      $error("keyed_wdt: KEY_W must lie in 1..DATA_W");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("keyed_wdt: RST_CYCLES must be at least 1");
   end
   if (CTRL_MSB >= DATA_W) begin : g_bad_ctrl
      $error("keyed_wdt: control bits exceed DATA_W");
   end

   logic             busy;
   logic             pulse_last;
   logic             unlocked;
   logic [KEY_W-1:0] key_q;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_zero;
   wdt_ctrl_t        ctl_q;
   logic             ctl_cen;
   logic             ctl_ren;
   logic             wr_key;
   logic             wr_cnt;
   logic             wr_ctl;
   logic             fire;
   logic [DATA_W-1:0] rd_mux;

   assign ctl_cen = ctl_q.cen;
   assign ctl_ren = ctl_q.ren;

   // Bus decode: frozen while the reset pulse is out
   assign wr_key = bus_we && (bus_addr == WDT_A_KEY)   && !busy;
   assign wr_cnt = bus_we && (bus_addr == WDT_A_COUNT) && !busy && unlocked;
   assign wr_ctl = bus_we && (bus_addr == WDT_A_CTRL)  && !busy && unlocked;

   wdt_key_gate #(
      .KEY_W   (KEY_W),
      .KEY_VAL (KEY_VAL)
   ) u_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (pulse_last),
      .key_we    (wr_key),
      .key_wdata (bus_wdata[KEY_W-1:0]),
      .key_q     (key_q),
      .unlocked  (unlocked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (pulse_last) begin
         ctl_q <= '0;
      end else if (wr_ctl) begin
         ctl_q.cen <= bus_wdata[CTRL_CEN_BIT];
         ctl_q.ren <= bus_wdata[CTRL_REN_BIT];
      end
   end

   wdt_downcount #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (pulse_last),
      .load     (wr_cnt),
      .load_val (bus_wdata[CNT_W-1:0]),
      .run      (ctl_cen && !busy),
      .cnt_q    (cnt_q),
      .zero     (cnt_zero)
   );

   assign fire = ctl_cen && ctl_ren && cnt_zero && !busy;

   wdt_rst_stretch #(
      .RST_CYCLES (RST_CYCLES)
   ) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .active (busy),
      .last   (pulse_last)
   );

   assign wdt_rst_o = busy;

   // Read path
   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         WDT_A_COUNT: rd_mux = DATA_W'(cnt_q);
         WDT_A_CTRL: begin
            rd_mux[CTRL_CEN_BIT] = ctl_cen;
            rd_mux[CTRL_REN_BIT] = ctl_ren;
         end
         WDT_A_KEY:  rd_mux = DATA_W'(key_q);
         default:    rd_mux = '0;
      endcase
   end

   if (RDATA_REG) begin : g_rd_flop
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q <= '0;
         end else begin
            rd_q <= rd_mux;
         end
      end
      assign bus_rdata = rd_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end

endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
   parameter int CNT_W      = 32,
   parameter int KEY_W      = 16,
   parameter int RST_CYCLES = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_we,
   input logic [1:0]       bus_addr,
   input logic             wdt_rst_o,
   input logic             unlocked,
   input logic             cen,
   input logic             ren,
   input logic [CNT_W-1:0] cnt,
   input logic [KEY_W-1:0] key
);

   localparam int LW = $clog2(RST_CYCLES + 2) + 1;

   logic [LW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= '0;
      end else if (wdt_rst_o) begin
         run_len <= run_len + LW'(1);
      end else begin
         run_len <= '0;
      end
   end

   p_locked_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 2'd1 && !unlocked && !wdt_rst_o) |=> $stable({cen, ren}));

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cen && !wdt_rst_o && cnt != '0 && !(bus_we && bus_addr == 2'd0 && unlocked))
      |=> (cnt == $past(cnt) - CNT_W'(1)));

   p_need_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wdt_rst_o && !(cen && ren)) |=> !wdt_rst_o);

   p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cen && ren && cnt == '0 && !wdt_rst_o) |=> wdt_rst_o);

   p_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= LW'(RST_CYCLES));

   p_len_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_rst_o) |-> (run_len == LW'(RST_CYCLES)));

   p_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_rst_o) |-> (!unlocked && !cen && !ren && cnt == '0 && key == '0));

   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_o |=> (!wdt_rst_o || $stable(key)));

endmodule

bind keyed_wdt keyed_wdt_chk #(
   .CNT_W      (CNT_W),
   .KEY_W      (KEY_W),
   .RST_CYCLES (RST_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .wdt_rst_o (wdt_rst_o),
   .unlocked  (unlocked),
   .cen       (ctl_cen),
   .ren       (ctl_ren),
   .cnt       (cnt_q),
   .key       (key_q)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        wdt_rst_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   keyed_wdt u_keyed_wdt (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .wdt_rst_o (wdt_rst_o)
   );

   // {we, addr, data, req}: writes drive data, reads expect data
   localparam int NSTEP = 23;
   localparam logic [38:0] STEPS [0:NSTEP-1] = '{
      {1'b0, 2'd0, 32'h0,        4'd1},  // R1 counter
      {1'b0, 2'd1, 32'h0,        4'd1},  // R1 control
      {1'b0, 2'd2, 32'h0,        4'd1},  // R1 key
      {1'b1, 2'd0, 32'h1234,     4'd2},  // R2 locked counter write
      {1'b0, 2'd0, 32'h0,        4'd2},
      {1'b1, 2'd1, 32'h5,        4'd2},  // R2 locked control write
      {1'b0, 2'd1, 32'h0,        4'd2},
      {1'b1, 2'd2, 32'h482E,     4'd3},  // R3 unlock
      {1'b0, 2'd2, 32'h482E,     4'd3},
      {1'b1, 2'd0, 32'hDEADBEEF, 4'd3},  // R3 load
      {1'b0, 2'd0, 32'hDEADBEEF, 4'd3},
      {1'b1, 2'd1, 32'h1,        4'd3},  // R3 reset-enable only
      {1'b0, 2'd1, 32'h1,        4'd3},
      {1'b1, 2'd2, 32'h0001,     4'd2},  // R2 relock
      {1'b1, 2'd0, 32'h55,       4'd2},
      {1'b0, 2'd0, 32'hDEADBEEF, 4'd2},
      {1'b1, 2'd1, 32'h4,        4'd2},
      {1'b0, 2'd1, 32'h1,        4'd2},
      {1'b0, 2'd0, 32'hDEADBEEF, 4'd9},  // R9 live read while locked
      {1'b1, 2'd2, 32'hFFFF482E, 4'd3},  // R3 upper key bits ignored
      {1'b0, 2'd2, 32'h482E,     4'd3},
      {1'b1, 2'd1, 32'h0,        4'd3},
      {1'b0, 2'd3, 32'h0,        4'd9}   // R9 spare address
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1", {31'd0, wdt_rst_o}, 32'd0);

      for (int i = 0; i < NSTEP; i++) begin
         if (STEPS[i][38]) begin
            wr(STEPS[i][37:36], STEPS[i][35:4]);
         end else begin
            rd(STEPS[i][37:36], STEPS[i][35:4], $sformatf("R%0d table %0d", STEPS[i][3:0], i));
         end
      end

      // R4: decrement and hold
      wr(2'd0, 32'd10);
      wr(2'd1, 32'h4);
      rd(2'd0, 32'd10, "R4");
      repeat (4) @(negedge clk);
      rd(2'd0, 32'd6, "R4");
      wr(2'd1, 32'h0);
      rd(2'd0, 32'd4, "R4");
      repeat (3) @(negedge clk);
      rd(2'd0, 32'd4, "R4");

      // R5: count-enable alone reaches zero and stays, no reset
      wr(2'd0, 32'd2);
      wr(2'd1, 32'h4);
      repeat (5) @(negedge clk);
      rd(2'd0, 32'd0, "R5");
      check("R5", {31'd0, wdt_rst_o}, 32'd0);
      wr(2'd1, 32'h1);
      repeat (3) @(negedge clk);
      check("R5", {31'd0, wdt_rst_o}, 32'd0);

      // R6: load zero, enable both, immediate reset
      wr(2'd0, 32'd0);
      wr(2'd1, 32'h5);
      check("R6", {31'd0, wdt_rst_o}, 32'd0);
      @(negedge clk);
      check("R6", {31'd0, wdt_rst_o}, 32'd1);
      // R8: key write held during the pulse
      bus_we = 1'b1;
      bus_addr = 2'd2;
      bus_wdata = 32'h1111;
      for (int k = 2; k <= 10; k++) begin
         @(negedge clk);
         check("R7", {31'd0, wdt_rst_o}, 32'd1);
      end
      bus_we = 1'b0;
      rd(2'd2, 32'h482E, "R8");
      for (int k = 11; k <= 16; k++) begin
         @(negedge clk);
         check("R7", {31'd0, wdt_rst_o}, 32'd1);
      end
      @(negedge clk);
      check("R7", {31'd0, wdt_rst_o}, 32'd0);
      rd(2'd2, 32'h0, "R7");
      rd(2'd1, 32'h0, "R7");
      rd(2'd0, 32'h0, "R7");
      wr(2'd1, 32'h5);
      repeat (2) @(negedge clk);
      check("R2", {31'd0, wdt_rst_o}, 32'd0);

      // R6: expiry after counting down
      wr(2'd2, 32'h482E);
      wr(2'd0, 32'd3);
      wr(2'd1, 32'h5);
      rd(2'd0, 32'd3, "R6");
      repeat (3) @(negedge clk);
      rd(2'd0, 32'd0, "R6");
      check("R6", {31'd0, wdt_rst_o}, 32'd0);
      @(negedge clk);
      check("R6", {31'd0, wdt_rst_o}, 32'd1);
      repeat (16) @(negedge clk);
      check("R7", {31'd0, wdt_rst_o}, 32'd0);
      rd(2'd2, 32'h0, "R7");

      done = 1'b1;
      finish_run();
   end

endmodule